// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is an 8-bit synchronous serial port. It can run as an SPI master that makes its own serial clock, or as an SPI slave that is clocked from outside. A 4-bit mode field picks the role and the clock source. In master mode the serial clock comes from one of three fixed divisions of the system clock, or it toggles once per pulse on a timer-tick input. In slave mode the external select pin either gates the port or is ignored. One buffer register serves both directions. Writing the buffer loads the shift register and, in master mode, starts a transfer. When a byte completes, it lands in the buffer and a full flag is set.

Two sticky error flags record misuse and stay set until software writes zero to them. One flag marks a buffer write made while a transfer is still shifting. The other marks a slave byte that arrived while the buffer still held an unread byte. An enable bit gives the serial pins to the port. When the bit is 0, every output enable of the port is low and the pins are left to general I/O. A simple register bus with a 2-bit address reaches the control, buffer and status registers. Reads are combinational.

Top module: `spi_xcvr`

## Requirements
- R1: With enable set, mode codes 0000, 0001 and 0010 make the port a master whose SCK period is 4, 16 and 64 system clocks.
- R2: Mode code 0011 makes the port a master whose SCK toggles once for each cycle in which `tmrTick` is high, so the SCK period is two ticks.
- R3: Control bit 4 sets the SCK idle level: 1 gives idle high and 0 gives idle low. A master outside a transfer holds SCK at that level.
- R4: Data moves MSB first. The MSB is on SDO from the buffer write. Each later bit appears on a leading SCK edge (an edge away from idle), and SDI is sampled on each trailing edge. After 8 bits the received byte is placed in the buffer and status bit 0 (full) is set. Reading the buffer register clears the full flag.
- R5: A buffer write during a transfer in progress sets status bit 1 (collision). That write is discarded and the transfer continues unchanged. The flag stays set until a status write with bit 1 at 0.
- R6: In slave mode, a byte that completes while the full flag is set is discarded and sets status bit 2 (overflow). The buffer keeps the old byte. The flag stays set until a status write with bit 2 at 0.
- R7: A master never sets the overflow flag. A master transfer that completes with the full flag already set overwrites the buffer.
- R8: Mode code 0100 is a slave gated by SS (active low). While SS is high, SDO output enable is low, SCK edges are ignored and the bit counter restarts, so an interrupted byte is dropped.
- R9: Mode code 0101 is a slave that ignores SS. Transfers complete with SS high, and SDO is driven whenever the port is enabled.
- R10: With enable (control bit 5) at 0, `sckOe` and `sdoOe` are low, buffer writes start no transfer, and activity on SCK and SDI changes nothing.
- R11: Mode codes 0110 to 1111 are reserved. With one of these codes set, the port drives no pin and completes no transfer.
- R12: Register map: address 0 is control (bits 3:0 mode, bit 4 idle level, bit 5 enable), address 1 is the buffer, and address 2 is status (bit 0 full, bit 1 collision, bit 2 overflow). All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (a buffer read clears full) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| tmrTick | input | 1 | Timer tick, used as the clock source in mode 0011 |
| sckIn | input | 1 | Serial clock pin input (slave) |
| sckOut | output | 1 | Serial clock pin output (master) |
| sckOe | output | 1 | Serial clock output enable |
| sdiIn | input | 1 | Serial data in |
| sdoOut | output | 1 | Serial data out |
| sdoOe | output | 1 | Serial data output enable |
| ssN | input | 1 | Slave select, active low |

## Verification
The properties assume that an external SCK holds each level for several system clocks. They also assume that SDI is steady from before a leading edge until after the matching trailing edge is synchronised, and that the control register is not rewritten during a transfer. The bench holds each slave SCK level for 8 clocks. It changes SDI only while SCK is idle and rewrites control only after a transfer has finished or been dropped. In master mode the bench wires SDO back to SDI, straight or inverted. This makes the received byte a known function of the sent byte.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // copy write data into shift register
    logic shiftOut;  // leading edge: move next bit onto SDO
    logic sampleIn;  // trailing edge: capture SDI
    logic commit;    // final bit: shift register into buffer
  } dpStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_BUF  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam logic [3:0] MD_FAST      = 4'd0;
  localparam logic [3:0] MD_MID       = 4'd1;
  localparam logic [3:0] MD_SLOW      = 4'd2;
  localparam logic [3:0] MD_TIMER     = 4'd3;
  localparam logic [3:0] MD_SLV_GATED = 4'd4;
  localparam logic [3:0] MD_SLV_FREE  = 4'd5;

endpackage

// File: rtl/spi_xcvr_dp.sv
module spi_xcvr_dp
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sdiIn,
  input  logic              sckIn,
  input  logic              ssNIn,
  output logic              sdoBit,
  output logic [DATA_W-1:0] rxBuf,
  output logic              sckSync,
  output logic              ssSync
);

  logic [DATA_W-1:0]      shiftReg;
  logic                   rxBit;
  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] ssPipe;

  // pin synchronisers; select resets to the deselected level
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe <= '0;
          ssPipe  <= '1;
        end else begin
          sckPipe <= sckIn;
          ssPipe  <= ssNIn;
        end
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe <= '0;
          ssPipe  <= '1;
        end else begin
          sckPipe <= {sckPipe[SYNC_STAGES-2:0], sckIn};
          ssPipe  <= {ssPipe[SYNC_STAGES-2:0], ssNIn};
        end
      end
    end
  endgenerate

  assign sckSync = sckPipe[SYNC_STAGES-1];
  assign ssSync  = ssPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBit    <= 1'b0;
      rxBuf    <= '0;
    end else begin
      if (strobe.loadTx) begin
        shiftReg <= loadData;
      end else if (strobe.shiftOut) begin
        shiftReg <= {shiftReg[DATA_W-2:0], rxBit};
      end
      if (strobe.sampleIn) begin
        rxBit <= sdiIn;
      end
      if (strobe.commit) begin
        rxBuf <= {shiftReg[DATA_W-2:0], sdiIn};
      end
    end
  end

  assign sdoBit = shiftReg[DATA_W-1];

endmodule

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [5:0] cfgWdata,
  input  logic       colKeep,
  input  logic       ovfKeep,
  input  logic       tmrTick,
  input  logic       sckSync,
  input  logic       ssSync,
  output dpStrobe_t  strobe,
  output logic       en,
  output logic       idleHigh,
  output logic [3:0] mode,
  output logic       fullFlag,
  output logic       colFlag,
  output logic       ovfFlag,
  output logic       sckInt,
  output logic       xferBusy,
  output logic       masterSel,
  output logic       sdoDrive
);

  localparam int CNT_W = (DIV_SLOW / 2 > 1) ? $clog2(DIV_SLOW / 2) : 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_FAST = CNT_W'(DIV_FAST / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_MID  = CNT_W'(DIV_MID / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_SLOW = CNT_W'(DIV_SLOW / 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  logic [5:0]       cfgReg;
  logic             busyM;
  logic [CNT_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sckPrev;

  logic masterMode, slaveMode, ssHonour, slaveSel;
  logic cfgWrite, bufWrite, statWrite, bufRead;
  logic halfTick, mLead, mTrail, sLead, sTrail, lead, trail, lastBit;
  logic collide, startM, cntClear, commitOk, ovfSet;

  assign mode     = cfgReg[3:0];
  assign idleHigh = cfgReg[4];
  assign en       = cfgReg[5];

  assign masterMode = (mode[3:2] == 2'b00);
  assign slaveMode  = (mode == MD_SLV_GATED) || (mode == MD_SLV_FREE);
  assign ssHonour   = (mode == MD_SLV_GATED);
  assign slaveSel   = en && slaveMode && (!ssHonour || !ssSync);

  assign cfgWrite  = busWr && (busAddr == ADDR_CTRL);
  assign bufWrite  = busWr && (busAddr == ADDR_BUF);
  assign statWrite = busWr && (busAddr == ADDR_STAT);
  assign bufRead   = busRd && (busAddr == ADDR_BUF);

  // half-period tick of the master clock
  always_comb begin
    case (mode)
      MD_FAST:  halfTick = (divCnt == HALF_FAST);
      MD_MID:   halfTick = (divCnt == HALF_MID);
      MD_SLOW:  halfTick = (divCnt == HALF_SLOW);
      MD_TIMER: halfTick = tmrTick;
      default:  halfTick = 1'b0;
    endcase
  end

  assign mLead  = busyM && halfTick && (sckInt == idleHigh);
  assign mTrail = busyM && halfTick && (sckInt != idleHigh);
  assign sLead  = slaveSel && (sckPrev == idleHigh) && (sckSync != idleHigh);
  assign sTrail = slaveSel && (sckPrev != idleHigh) && (sckSync == idleHigh);
  assign lead   = mLead || sLead;
  assign trail  = mTrail || sTrail;
  assign lastBit = trail && (bitCnt == LAST_BIT);

  assign xferBusy = masterMode ? busyM : (slaveMode && (bitCnt != '0));
  assign collide  = bufWrite && en && xferBusy;
  assign startM   = bufWrite && !collide && en && masterMode;
  assign cntClear = !en || !(masterMode || slaveMode) || (ssHonour && ssSync);
  assign commitOk = lastBit && (masterMode || !fullFlag);
  assign ovfSet   = lastBit && slaveMode && fullFlag;

  assign strobe.loadTx   = bufWrite && !collide;
  assign strobe.shiftOut = lead && (bitCnt != '0);
  assign strobe.sampleIn = trail;
  assign strobe.commit   = commitOk;

  assign masterSel = en && masterMode;
  assign sdoDrive  = masterSel || slaveSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      busyM    <= 1'b0;
      divCnt   <= '0;
      sckInt   <= 1'b0;
      bitCnt   <= '0;
      sckPrev  <= 1'b0;
      fullFlag <= 1'b0;
      colFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      sckPrev <= sckSync;
      if (cfgWrite) cfgReg <= cfgWdata;

      // master clock engine
      if (!masterSel) begin
        busyM  <= 1'b0;
        divCnt <= '0;
        sckInt <= idleHigh;
      end else if (startM) begin
        busyM  <= 1'b1;
        divCnt <= '0;
      end else if (busyM) begin
        if (halfTick) begin
          sckInt <= ~sckInt;
          divCnt <= '0;
          if (lastBit) busyM <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        sckInt <= idleHigh;
      end

      // bit counter shared by both roles
      if (cntClear) begin
        bitCnt <= '0;
      end else if (trail) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end

      // status flags
      if (commitOk) fullFlag <= 1'b1;
      else if (bufRead) fullFlag <= 1'b0;

      if (collide) colFlag <= 1'b1;
      else if (statWrite && !colKeep) colFlag <= 1'b0;

      if (ovfSet) ovfFlag <= 1'b1;
      else if (statWrite && !ovfKeep) ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tmrTick,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic              sdoOe,
  input  logic              ssN
);

  localparam int CFG_PAD  = DATA_W - 6;
  localparam int STAT_PAD = DATA_W - 3;

  dpStrobe_t         strobe;
  logic              ctrlEn, idleHigh, fullFlag, colFlag, ovfFlag;
  logic              sckInt, xferBusy, masterSel, sdoDrive;
  logic [3:0]        mode;
  logic              sckSync, ssSync, sdoBit;
  logic [DATA_W-1:0] rxBuf;

  spi_xcvr_ctrl #(
    .DATA_W(DATA_W), .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .cfgWdata(busWdata[5:0]), .colKeep(busWdata[1]), .ovfKeep(busWdata[2]),
    .tmrTick(tmrTick), .sckSync(sckSync), .ssSync(ssSync), .strobe(strobe),
    .en(ctrlEn), .idleHigh(idleHigh), .mode(mode), .fullFlag(fullFlag),
    .colFlag(colFlag), .ovfFlag(ovfFlag), .sckInt(sckInt), .xferBusy(xferBusy),
    .masterSel(masterSel), .sdoDrive(sdoDrive)
  );

  spi_xcvr_dp #(.DATA_W(DATA_W), .SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(busWdata), .sdiIn(sdiIn),
    .sckIn(sckIn), .ssNIn(ssN), .sdoBit(sdoBit), .rxBuf(rxBuf),
    .sckSync(sckSync), .ssSync(ssSync)
  );

  assign sckOut = sckInt;
  assign sckOe  = masterSel;
  assign sdoOut = sdoBit;
  assign sdoOe  = sdoDrive;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = {{CFG_PAD{1'b0}}, ctrlEn, idleHigh, mode};
      ADDR_BUF:  busRdata = rxBuf;
      ADDR_STAT: busRdata = {{STAT_PAD{1'b0}}, ovfFlag, colFlag, fullFlag};
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [1:0] flagWdata,
  input logic       en,
  input logic       idleHigh,
  input logic [3:0] mode,
  input logic       busy,
  input logic       sckOut,
  input logic       sckOe,
  input logic       sdoOe,
  input logic       ssSync,
  input logic       colFlag,
  input logic       ovfFlag
);

  // R10: disabled port drives nothing
  a_r10_pins_released: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> (!sckOe && !sdoOe));

  // R8: gated slave with SS high leaves SDO undriven
  a_r8_ss_tristate: assert property (@(posedge clk) disable iff (!rstN)
    (en && mode == 4'd4 && ssSync) |-> !sdoOe);

  // R7: overflow only rises from a slave mode
  a_r7_master_no_ovf: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(mode) == 4'd4 || $past(mode) == 4'd5));

  // R5: collision flag sticky until cleared by a status write
  a_r5_col_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (colFlag && !(busWr && busAddr == 2'd2 && !flagWdata[0])) |=> colFlag);

  // R6: overflow flag sticky until cleared by a status write
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWr && busAddr == 2'd2 && !flagWdata[1])) |=> ovfFlag);

  // R3: idle master holds SCK at the selected level
  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && !busy && $past(!busy) && $stable(idleHigh)) |-> (sckOut == idleHigh));

endmodule

bind spi_xcvr spi_xcvr_chk uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .flagWdata(busWdata[2:1]), .en(ctrlEn), .idleHigh(idleHigh), .mode(mode),
  .busy(xferBusy), .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe),
  .ssSync(ssSync), .colFlag(colFlag), .ovfFlag(ovfFlag)
);

// File: tb/sim_spi_xcvr.sv
module sim_spi_xcvr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] busAddr = 0;
  logic       busWr = 0, busRd = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic       tmrTick, sckIn = 0, sckOut, sckOe, sdiIn, sdoOut, sdoOe, ssN = 0;
  logic [1:0] loopSel = 0;   // 0 straight loopback, 1 inverted, 2 bench drives
  logic       slvSdi = 0;
  logic       tickOn = 0;
  int         cyc = 0, checks = 0, errors = 0;
  logic [7:0] expQ[$];
  bit         done = 0;

  assign sdiIn = (loopSel == 2'd0) ? sdoOut : (loopSel == 2'd1) ? ~sdoOut : slvSdi;

  spi_xcvr u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .tmrTick(tmrTick), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .sdiIn(sdiIn), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .ssN(ssN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    tmrTick = 0;
    forever begin
      @(negedge clk) tmrTick = tickOn;
      @(negedge clk) tmrTick = 0;
      @(negedge clk);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard: driver pushes, monitor pops on each received byte
  task automatic pushExp(input logic [7:0] v);
    expQ.push_back(v);
  endtask

  task automatic popCmp(input logic [7:0] act, input string tag);
    logic [7:0] e;
    if (expQ.size() == 0) begin
      check({tag, " queue empty"}, 1, 0);
    end else begin
      e = expQ.pop_front();
      check(tag, act, e);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 0;
  endtask

  task automatic waitFull();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      busRead(2'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic measureSck(input logic idle, output int per);
    int t0;
    int g = 0;
    while (sckOut == idle && g < 3000) begin @(negedge clk); g++; end
    t0 = cyc;
    while (sckOut != idle && g < 3000) begin @(negedge clk); g++; end
    while (sckOut == idle && g < 3000) begin @(negedge clk); g++; end
    per = cyc - t0;
  endtask

  task automatic masterRun(input logic [3:0] md, input logic pol, input logic [1:0] lp,
                           input logic [7:0] tx, input int expPer, input string tag);
    int per;
    logic [7:0] d;
    loopSel = lp;
    busWrite(2'd0, {2'b00, 1'b1, pol, md});
    repeat (2) @(negedge clk);
    check({tag, " R3 idle level"}, sckOut, pol);
    pushExp(lp == 2'd1 ? ~tx : tx);
    busWrite(2'd1, tx);
    measureSck(pol, per);
    check({tag, " SCK period"}, per, expPer);
    waitFull();
    busRead(2'd1, d);
    popCmp(d, {tag, " R4 received byte"});
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input logic pol, input int nBits,
                           output logic [7:0] got);
    got = 0;
    for (int i = 0; i < nBits; i++) begin
      slvSdi = tx[7-i];
      sckIn = pol;
      repeat (8) @(negedge clk);
      sckIn = ~pol;
      repeat (8) @(negedge clk);
      got = {got[6:0], sdoOut};
      sckIn = pol;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, got;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R12 reset state, R10 pins released
    busRead(2'd0, d); check("R12 reset control", d, 8'h00);
    busRead(2'd2, d); check("R12 reset status", d, 8'h00);
    check("R10 reset sckOe", sckOe, 0);
    check("R10 reset sdoOe", sdoOe, 0);

    // R1 dividers, R3 polarity, R4 ordering
    masterRun(4'd0, 1'b0, 2'd0, 8'hA5, 4,  "R1 div4");
    masterRun(4'd1, 1'b0, 2'd1, 8'h3C, 16, "R1 div16");
    masterRun(4'd2, 1'b1, 2'd0, 8'h81, 64, "R1 div64");
    busRead(2'd0, d); check("R12 control readback", d, 8'h32);

    // R2 timer source: tick every 3 clocks gives period 6
    tickOn = 1;
    masterRun(4'd3, 1'b0, 2'd1, 8'h6E, 6, "R2 timer");
    tickOn = 0;

    // R5 collision, R7 master overwrite
    loopSel = 2'd0;
    busWrite(2'd0, 8'h20);
    pushExp(8'h55);
    busWrite(2'd1, 8'h55);
    busWrite(2'd1, 8'hFF);
    waitFull();
    busRead(2'd2, d); check("R5 collision set", d, 8'h03);
    busRead(2'd1, d); popCmp(d, "R5 ignored write leaves byte");
    busWrite(2'd1, 8'h12);
    waitFull();
    busWrite(2'd1, 8'h34);
    repeat (40) @(negedge clk);
    busRead(2'd2, d); check("R7 no overflow in master, R5 sticky", d, 8'h03);
    busRead(2'd1, d); check("R7 master overwrites buffer", d, 8'h34);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, d); check("R5 collision cleared, R4 read clears full", d, 8'h00);

    // R8 gated slave transfer
    loopSel = 2'd2; ssN = 0; sckIn = 0;
    busWrite(2'd0, 8'h24);
    busWrite(2'd1, 8'h4B);
    pushExp(8'h96);
    slaveXfer(8'h96, 1'b0, 8, got);
    check("R4 slave sends MSB first", got, 8'h4B);
    busRead(2'd2, d); check("R4 slave full", d, 8'h01);

    // R6 overflow
    slaveXfer(8'h11, 1'b0, 8, got);
    busRead(2'd2, d); check("R6 overflow set", d, 8'h05);
    busRead(2'd1, d); popCmp(d, "R6 old byte kept");
    busRead(2'd2, d); check("R6 overflow sticky", d, 8'h04);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, d); check("R6 overflow cleared", d, 8'h00);

    // R8 SS high: tri-state, ignored clocks, counter restart
    ssN = 1;
    repeat (4) @(negedge clk);
    check("R8 SS high sdoOe", sdoOe, 0);
    slaveXfer(8'hF0, 1'b0, 8, got);
    busRead(2'd2, d); check("R8 clocks ignored with SS high", d, 8'h00);
    ssN = 0; repeat (4) @(negedge clk);
    check("R8 SS low sdoOe", sdoOe, 1);
    slaveXfer(8'hE7, 1'b0, 3, got);
    ssN = 1; repeat (4) @(negedge clk);
    ssN = 0; repeat (4) @(negedge clk);
    pushExp(8'h5A);
    slaveXfer(8'h5A, 1'b0, 8, got);
    busRead(2'd2, d); check("R8 partial byte dropped", d, 8'h01);
    busRead(2'd1, d); popCmp(d, "R8 byte after restart");

    // R9 SS ignored, idle-high clock
    ssN = 1; sckIn = 1;
    repeat (4) @(negedge clk);
    busWrite(2'd0, 8'h35);
    busWrite(2'd1, 8'hC6);
    repeat (4) @(negedge clk);
    check("R9 SDO driven with SS high", sdoOe, 1);
    pushExp(8'h3E);
    slaveXfer(8'h3E, 1'b1, 8, got);
    check("R9 slave tx idle-high", got, 8'hC6);
    busRead(2'd1, d); popCmp(d, "R9 slave rx with SS ignored");

    // R11 reserved code
    sckIn = 0; ssN = 0; loopSel = 2'd0;
    repeat (4) @(negedge clk);
    busWrite(2'd0, 8'h28);
    busWrite(2'd1, 8'hAA);
    repeat (100) @(negedge clk);
    check("R11 reserved sckOe", sckOe, 0);
    check("R11 reserved sdoOe", sdoOe, 0);
    busRead(2'd2, d); check("R11 no transfer", d, 8'h00);

    // R10 disabled master and disabled slave
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, 8'h77);
    repeat (100) @(negedge clk);
    check("R10 disabled sckOe", sckOe, 0);
    check("R10 disabled sdoOe", sdoOe, 0);
    busRead(2'd2, d); check("R10 disabled master idle", d, 8'h00);
    loopSel = 2'd2;
    busWrite(2'd0, 8'h04);
    slaveXfer(8'h99, 1'b0, 8, got);
    busRead(2'd2, d); check("R10 disabled slave ignores SCK", d, 8'h00);

    check("scoreboard drained", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule